// File: doc/BRIEF.md
# Subscriber Loop Hook Supervisor with Automatic Ring Trip

This block supervises the hook state of a single subscriber line. It watches a sampled loop-detect bit, which is high whenever loop current exceeds the off-hook threshold. Outside ringing it debounces each make and each break over a qualification window counted in millisecond ticks. The block therefore follows dial pulses and still rejects short glitches. Both the switch-hook output and the indicator output are active low, so a low level means off-hook.

The host asks for ringing by pulling an active-low request low. The block then energises the ring relay command and switches to a ringing filter. In that mode the hook outputs are frozen, and only an unbroken run of off-hook samples, longer than any ringing half-cycle or relay transient, is accepted. Once that run completes, the block trips the ring on its own: the relay command drops and off-hook is reported on the same clock edge. The relay then stays off until the host withdraws its request.

If the host withdraws the request before a trip, the relay drops at once. A guard interval follows in which loop-detect is ignored, so the relay switching out cannot be mistaken for a hook change. After the guard interval, normal detection resumes.

Top module: `hook_supervisor`

## Requirements
- R1: While reset is asserted, and on the first clock after its release, hookN, ledN and relayCmdN are all 1 (on-hook, relay off). The reset is asynchronous and active low.
- R2: ledN always carries the same value as hookN.
- R3: With no ringing, hookN changes only at the HOOK_MS-th msTick of an unbroken run in which loopDetect differs from the reported state (loopDetect 1 means off-hook, hookN 0 means off-hook). A shorter run has no effect.
- R4: Consecutive qualified breaks and makes each toggle hookN, so the outputs follow dial pulses.
- R5: ringReqN = 0 seen in the normal state drives relayCmdN to 0 (relay energised) on the next clock edge. relayCmdN never goes low unless ringReqN was 0 on the previous edge.
- R6: While relayCmdN is 0, hookN holds its value whatever loopDetect does.
- R7: During ringing, the TRIP_MS-th msTick of an unbroken run of loopDetect = 1 sets relayCmdN to 1 and hookN to 0 on the same edge. A single loopDetect = 0 cycle restarts the run.
- R8: After a trip, relayCmdN stays 1 while ringReqN stays 0, and hook debouncing works as in R3. Raising ringReqN returns the block to the normal state, and a new request rings again.
- R9: Raising ringReqN during ringing without a trip sets relayCmdN to 1 on the next edge. loopDetect is then ignored for GUARD_MS msTicks, after which an R3 qualification starts from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| msTick | input | 1 | One-cycle strobe, once per millisecond |
| loopDetect | input | 1 | Sampled loop-current comparator, 1 = above off-hook threshold |
| ringReqN | input | 1 | Ringing request from the control register, 0 = ring |
| hookN | output | 1 | Switch-hook status, 0 = off-hook |
| ledN | output | 1 | Indicator drive, 0 = off-hook |
| relayCmdN | output | 1 | Ring relay command, 0 = energise |

## Verification
The bench builds the supervisor with HOOK_MS = 4, TRIP_MS = 7 and GUARD_MS = 3, and generates a tick every four clocks. Each window is then only a few ticks long, so the bench can step one tick at a time across every qualification edge. It checks the last tick before each window closes and the tick on which it closes, as well as a one-sample break in the ring-trip run, dial pulses and a hook change during the guard interval. These short windows also let an asynchronous reset during ringing fit into a short run.

// File: rtl/hook_sup_pkg.sv
package hook_sup_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RING  = 2'd1,
    ST_TRIP  = 2'd2,
    ST_GUARD = 2'd3
  } supState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClear;
    logic hookFlip;
    logic hookSetOff;
    logic relayOn;
  } supStrobe_t;

  localparam int HIT_HOOK  = 0;
  localparam int HIT_TRIP  = 1;
  localparam int HIT_GUARD = 2;
  localparam int NUM_HITS  = 3;

endpackage

// File: rtl/hook_sup_datapath.sv
module hook_sup_datapath
  import hook_sup_pkg::*;
#(
  parameter int HOOK_MS  = 20,
  parameter int TRIP_MS  = 110,
  parameter int GUARD_MS = 20
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                msTick,
  input  logic                loopDetect,
  input  supStrobe_t          strobes,
  output logic [NUM_HITS-1:0] hitVec,
  output logic                mismatch,
  output logic                hookOff
);

  localparam int MAX_MS = (HOOK_MS > TRIP_MS)
                          ? ((HOOK_MS > GUARD_MS) ? HOOK_MS : GUARD_MS)
                          : ((TRIP_MS > GUARD_MS) ? TRIP_MS : GUARD_MS);
  localparam int CNT_W = $clog2(MAX_MS + 1);
  localparam int LIMITS [NUM_HITS] = '{HOOK_MS, TRIP_MS, GUARD_MS};

  logic [CNT_W-1:0] cntQ;

  // one shared window counter; the control decides what it is timing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 cntQ <= '0;
    else if (strobes.cntClear) cntQ <= '0;
    else if (msTick)           cntQ <= cntQ + 1'b1;
  end

  // one terminal-count comparator per window length
  for (genvar g = 0; g < NUM_HITS; g++) begin : g_hit
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMITS[g] - 1);
    assign hitVec[g] = msTick && (cntQ == LAST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   hookOff <= 1'b0;
    else if (strobes.hookSetOff) hookOff <= 1'b1;
    else if (strobes.hookFlip)   hookOff <= ~hookOff;
  end

  assign mismatch = loopDetect ^ hookOff;

endmodule

// File: rtl/hook_sup_control.sv
module hook_sup_control
  import hook_sup_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                ringReqN,
  input  logic                loopDetect,
  input  logic [NUM_HITS-1:0] hitVec,
  input  logic                mismatch,
  output supStrobe_t          strobes
);

  supState_t stQ, stNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stQ <= ST_IDLE;
    else       stQ <= stNext;
  end

  always_comb begin
    stNext             = stQ;
    strobes            = '0;
    strobes.relayOn    = (stQ == ST_RING);
    unique case (stQ)
      ST_IDLE: begin
        if (!ringReqN) begin
          stNext           = ST_RING;
          strobes.cntClear = 1'b1;
        end else if (mismatch) begin
          if (hitVec[HIT_HOOK]) begin
            strobes.hookFlip = 1'b1;
            strobes.cntClear = 1'b1;
          end
        end else begin
          strobes.cntClear = 1'b1;
        end
      end
      ST_RING: begin
        if (ringReqN) begin
          stNext           = ST_GUARD;
          strobes.cntClear = 1'b1;
        end else if (!loopDetect) begin
          strobes.cntClear = 1'b1;
        end else if (hitVec[HIT_TRIP]) begin
          stNext             = ST_TRIP;
          strobes.hookSetOff = 1'b1;
          strobes.cntClear   = 1'b1;
        end
      end
      ST_TRIP: begin
        if (ringReqN) begin
          stNext           = ST_IDLE;
          strobes.cntClear = 1'b1;
        end else if (mismatch) begin
          if (hitVec[HIT_HOOK]) begin
            strobes.hookFlip = 1'b1;
            strobes.cntClear = 1'b1;
          end
        end else begin
          strobes.cntClear = 1'b1;
        end
      end
      ST_GUARD: begin
        if (hitVec[HIT_GUARD]) begin
          stNext           = ST_IDLE;
          strobes.cntClear = 1'b1;
        end
      end
      default: begin
        stNext           = ST_IDLE;
        strobes.cntClear = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/hook_supervisor.sv
module hook_supervisor #(
  parameter int HOOK_MS  = 20,
  parameter int TRIP_MS  = 110,
  parameter int GUARD_MS = 20
) (
  input  logic clk,
  input  logic rstN,
  input  logic msTick,
  input  logic loopDetect,
  input  logic ringReqN,
  output logic hookN,
  output logic ledN,
  output logic relayCmdN
);

  import hook_sup_pkg::*;

  supStrobe_t          strobes;
  logic [NUM_HITS-1:0] hitVec;
  logic                mismatch;
  logic                hookOff;

  hook_sup_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .ringReqN   (ringReqN),
    .loopDetect (loopDetect),
    .hitVec     (hitVec),
    .mismatch   (mismatch),
    .strobes    (strobes)
  );

  hook_sup_datapath #(
    .HOOK_MS  (HOOK_MS),
    .TRIP_MS  (TRIP_MS),
    .GUARD_MS (GUARD_MS)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .msTick     (msTick),
    .loopDetect (loopDetect),
    .strobes    (strobes),
    .hitVec     (hitVec),
    .mismatch   (mismatch),
    .hookOff    (hookOff)
  );

  assign hookN     = ~hookOff;
  assign ledN      = ~hookOff;
  assign relayCmdN = ~strobes.relayOn;

endmodule

// File: rtl/hook_supervisor_chk.sv
module hook_supervisor_chk (
  input logic clk,
  input logic rstN,
  input logic msTick,
  input logic loopDetect,
  input logic ringReqN,
  input logic hookN,
  input logic ledN,
  input logic relayCmdN
);

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rstN |=> (hookN && relayCmdN));                                  // R1

  AST_LED_TRACKS_HOOK: assert property (@(posedge clk) disable iff (!rstN)
    ledN == hookN);                                                   // R2

  AST_HOOK_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(hookN) |-> $past(msTick));                               // R3

  AST_RELAY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    $fell(relayCmdN) |-> $past(!ringReqN));                           // R5

  AST_HOOK_FROZEN_RINGING: assert property (@(posedge clk) disable iff (!rstN)
    !relayCmdN |=> (relayCmdN || $stable(hookN)));                    // R6

  AST_TRIP_REPORTS_OFFHOOK: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(relayCmdN) && $past(!ringReqN)) |-> !hookN);               // R7

  AST_RELEASE_DROPS_RELAY: assert property (@(posedge clk) disable iff (!rstN)
    (!relayCmdN && ringReqN) |=> relayCmdN);                          // R9

endmodule

bind hook_supervisor hook_supervisor_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .msTick     (msTick),
  .loopDetect (loopDetect),
  .ringReqN   (ringReqN),
  .hookN      (hookN),
  .ledN       (ledN),
  .relayCmdN  (relayCmdN)
);

// File: tb/hook_supervisor_test.sv
module hook_supervisor_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic msTick = 1'b0;
  logic loopDetect = 1'b0;
  logic ringReqN = 1'b1;
  logic hookN, ledN, relayCmdN;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [1:0] tickDiv = 2'd0;

  always #4 clk = ~clk;

  always @(negedge clk) begin
    tickDiv = tickDiv + 2'd1;
    msTick  = (tickDiv == 2'd0);
  end

  hook_supervisor #(.HOOK_MS(4), .TRIP_MS(7), .GUARD_MS(3)) uut (
    .clk(clk), .rstN(rstN), .msTick(msTick), .loopDetect(loopDetect),
    .ringReqN(ringReqN), .hookN(hookN), .ledN(ledN), .relayCmdN(relayCmdN)
  );

  // {loop, req, ticks[3:0], expHookN, expRelayN, reqTag[3:0]}
  localparam int NV = 21;
  localparam logic [11:0] VEC [NV] = '{
    {1'b0, 1'b1, 4'd2, 1'b1, 1'b1, 4'd3},  // R3 idle on-hook stays
    {1'b1, 1'b1, 4'd3, 1'b1, 1'b1, 4'd3},  // R3 3 ticks not enough
    {1'b1, 1'b1, 4'd1, 1'b0, 1'b1, 4'd3},  // R3 4th tick qualifies
    {1'b0, 1'b1, 4'd3, 1'b0, 1'b1, 4'd3},  // R3 short break
    {1'b1, 1'b1, 4'd2, 1'b0, 1'b1, 4'd3},  // R3 glitch discarded
    {1'b0, 1'b1, 4'd4, 1'b1, 1'b1, 4'd4},  // R4 dial break
    {1'b1, 1'b1, 4'd4, 1'b0, 1'b1, 4'd4},  // R4 dial make
    {1'b0, 1'b1, 4'd4, 1'b1, 1'b1, 4'd4},  // R4 hang up
    {1'b0, 1'b0, 4'd2, 1'b1, 1'b0, 4'd5},  // R5 ringing on
    {1'b1, 1'b0, 4'd6, 1'b1, 1'b0, 4'd6},  // R6 filter holds
    {1'b0, 1'b0, 4'd1, 1'b1, 1'b0, 4'd7},  // R7 one on-hook sample
    {1'b1, 1'b0, 4'd6, 1'b1, 1'b0, 4'd7},  // R7 run restarted
    {1'b1, 1'b0, 4'd1, 1'b0, 1'b1, 4'd7},  // R7 trip at 7th tick
    {1'b1, 1'b0, 4'd5, 1'b0, 1'b1, 4'd8},  // R8 stays cut
    {1'b0, 1'b0, 4'd4, 1'b1, 1'b1, 4'd8},  // R8 debounce after trip
    {1'b0, 1'b1, 4'd2, 1'b1, 1'b1, 4'd8},  // R8 release
    {1'b0, 1'b0, 4'd2, 1'b1, 1'b0, 4'd8},  // R8 fresh request rings
    {1'b0, 1'b1, 4'd1, 1'b1, 1'b1, 4'd9},  // R9 release drops relay
    {1'b1, 1'b1, 4'd2, 1'b1, 1'b1, 4'd9},  // R9 guard ignores loop
    {1'b1, 1'b1, 4'd3, 1'b1, 1'b1, 4'd9},  // R9 count restarts
    {1'b1, 1'b1, 4'd1, 1'b0, 1'b1, 4'd9}   // R9 qualifies after guard
  };

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic waitTicks(int n);
    repeat (n) begin
      @(posedge clk);
      while (!msTick) @(posedge clk);
    end
    @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 hookN in reset", hookN, 1'b1);
    chk("R1 ledN in reset", ledN, 1'b1);
    chk("R1 relayCmdN in reset", relayCmdN, 1'b1);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 hookN after release", hookN, 1'b1);
    chk("R1 relayCmdN after release", relayCmdN, 1'b1);

    for (int i = 0; i < NV; i++) begin
      loopDetect = VEC[i][11];
      ringReqN   = VEC[i][10];
      waitTicks(int'(VEC[i][9:6]));
      chk($sformatf("R%0d step %0d hookN", VEC[i][3:0], i), hookN, VEC[i][5]);
      chk($sformatf("R2 step %0d ledN", i), ledN, hookN);
      chk($sformatf("R%0d step %0d relayCmdN", VEC[i][3:0], i), relayCmdN, VEC[i][4]);
    end

    // R5 relay energised exactly one edge after the request
    loopDetect = 1'b0;
    ringReqN   = 1'b1;
    waitTicks(5);
    ringReqN = 1'b0;
    @(negedge clk);
    chk("R5 relay one edge after request", relayCmdN, 1'b0);

    // R1 asynchronous reset while ringing
    waitTicks(1);
    rstN = 1'b0;
    #1;
    chk("R1 async reset drops relay", relayCmdN, 1'b1);
    chk("R1 async reset hook on", hookN, 1'b1);
    ringReqN = 1'b1;
    @(negedge clk);
    rstN = 1'b1;
    waitTicks(2);
    chk("R1 idle after reset", relayCmdN, 1'b1);

    summary();
  end

endmodule